// File: doc/BRIEF.md
# DRAM Bank Row-Buffer Sequencer

This block drives one DRAM bank that owns a single row buffer. A client offers one access at a time, made of a row address and a column address. The block then issues only the phases that the current buffer state needs. A hit needs the column phase alone. An empty buffer needs activation and then the column phase. A different open row needs precharge, then activation, then the column phase. When the access finishes, the block pulses `done_o` once and reports the kind of access that was served. The length of each phase is a parameter, counted in clock cycles.

The `close_page_i` input selects the page policy. It is sampled when a request is accepted. Under open-page policy the row stays latched in the buffer, so a later access to the same row is served as a hit. Under close-page policy the bank starts precharging in the background in the same cycle that completion is signalled. That precharge does not delay the completion. A request that lands before the background precharge has finished is held until the precharge ends, and only then does its activation begin. The open row is visible on the ports, so a host or a test can follow what the buffer holds.

Top module: `bank_rowbuf_ctrl`

## Requirements
- R1: After reset `ready_o` is 1, `done_o` is 0 and `open_valid_o` is 0, so no row is open.
- R2: An access to the row that is currently open raises `done_o` T_COL clock edges after the accepting edge. `kind_o` reads 2'b00 and `done_col_o` reads the requested column.
- R3: An access while no row is open and no background precharge is pending raises `done_o` T_ACT+T_COL edges after acceptance, with `kind_o` = 2'b01.
- R4: An access to a row other than the open one raises `done_o` T_PRE+T_ACT+T_COL edges after acceptance, with `kind_o` = 2'b10.
- R5: After an access under open-page policy, `open_valid_o` is 1 and `open_row_o` equals that access's row, from the done cycle onward.
- R6: After an access under close-page policy, `open_valid_o` is 0 in the done cycle. The completion latency is the same as under open-page policy.
- R7: A background precharge lasts T_PRE cycles, starting with the done cycle. Suppose an empty-buffer request is accepted in a cycle where r such cycles remain, counting that cycle. Its latency is then T_ACT+T_COL+max(r-1,0).
- R8: `ready_o` is high in idle and low from the cycle after acceptance until the done cycle. A `req_valid_i` pulse while `ready_o` is low has no effect on the latency, the class or the open row.
- R9: `done_o` is high for exactly one cycle per accepted request.
- R10: The policy is taken from `close_page_i` at the accepting edge. Changes to it while the access is in progress do not alter that access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| close_page_i | input | 1 | 1 = close-page policy, 0 = open-page policy |
| req_valid_i | input | 1 | Request offered this cycle |
| req_row_i | input | ROW_W | Row address of the request |
| req_col_i | input | COL_W | Column address of the request |
| ready_o | output | 1 | Block can accept a request |
| done_o | output | 1 | One-cycle completion pulse |
| kind_o | output | 2 | Access class: 00 hit, 01 empty, 10 conflict |
| done_col_o | output | COL_W | Column of the completed access |
| open_valid_o | output | 1 | A row is held in the row buffer |
| open_row_o | output | ROW_W | Row held in the row buffer |

## Verification
The hardest situation to reach is an empty-buffer request that arrives while a close-page background precharge is still partly pending. Only then is the latency stretched by the remaining precharge cycles. The stimulus reaches it in two ways. Directed accesses are placed 0, 1 and 3 cycles after a close-page completion. The random phase draws idle gaps from 0 to 6 cycles and mixes the policies, so every remaining-precharge count appears. A small row set keeps hits and conflicts frequent, and the policy input is flipped while each access is in flight.

// File: rtl/rowbuf_pkg.sv
// Package: shared types and helpers for the bank row-buffer sequencer.
// Assumes: access class encoding is fixed at 00 hit, 01 empty, 10 conflict.
package rowbuf_pkg;

    typedef enum logic [1:0] {
        ACC_HIT      = 2'b00,
        ACC_EMPTY    = 2'b01,
        ACC_CONFLICT = 2'b10
    } acc_kind_e;

    typedef enum logic [2:0] {
        SQ_IDLE  = 3'd0,
        SQ_DRAIN = 3'd1,
        SQ_PRE   = 3'd2,
        SQ_ACT   = 3'd3,
        SQ_COL   = 3'd4
    } seq_state_e;

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/rowbuf_phase_cnt.sv
// Module: down counter that times one bank phase.
// Assumes: load has priority; the counter holds at zero; expired_o is high
// while the count is zero, so a phase loaded with T-1 lasts T cycles.
module rowbuf_phase_cnt #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             expired_o
);

    logic [CNT_W-1:0] cnt_q;

    // Load a new phase length or count down toward zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // Report the end of the current phase.
    always_comb begin
        expired_o = (cnt_q == '0);
    end

endmodule

// File: rtl/rowbuf_drain.sv
// Module: background precharge timer used by close-page policy.
// Assumes: start_i pulses on the edge that raises done; the precharge then
// occupies T_PRE cycles, beginning with the done cycle.
module rowbuf_drain #(
    parameter int T_PRE = 4,
    parameter int CNT_W = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic busy_o,
    output logic last_o
);

    logic [CNT_W-1:0] left_q;

    // Load the precharge length on start, then count it down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_q <= '0;
        end else if (start_i) begin
            left_q <= CNT_W'(T_PRE);
        end else if (left_q != '0) begin
            left_q <= left_q - 1'b1;
        end
    end

    // Busy while cycles remain; last marks the final precharge cycle.
    always_comb begin
        busy_o = (left_q != '0);
        last_o = (left_q == CNT_W'(1));
    end

endmodule

// File: rtl/rowbuf_tracker.sv
// Module: holds the open row of the bank and classifies a probe address.
// Assumes: fill and invalidate never arrive in the same cycle; fill wins.
module rowbuf_tracker
    import rowbuf_pkg::*;
#(
    parameter int ROW_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ROW_W-1:0] probe_row_i,
    input  logic             fill_i,
    input  logic [ROW_W-1:0] fill_row_i,
    input  logic             invalidate_i,
    output logic             open_valid_o,
    output logic [ROW_W-1:0] open_row_o,
    output acc_kind_e        kind_o
);

    logic             valid_q;
    logic [ROW_W-1:0] row_q;

    // Record a row on activation, forget it on precharge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            row_q   <= '0;
        end else if (fill_i) begin
            valid_q <= 1'b1;
            row_q   <= fill_row_i;
        end else if (invalidate_i) begin
            valid_q <= 1'b0;
        end
    end

    // Classify the probe row against the buffer contents.
    always_comb begin
        if (!valid_q) begin
            kind_o = ACC_EMPTY;
        end else if (row_q == probe_row_i) begin
            kind_o = ACC_HIT;
        end else begin
            kind_o = ACC_CONFLICT;
        end
        open_valid_o = valid_q;
        open_row_o   = row_q;
    end

endmodule

// File: rtl/rowbuf_seq.sv
// Module: phase sequencer; walks precharge, activate and column phases.
// Assumes: requests arrive only in idle; the class is taken at acceptance;
// a hit can never coincide with a pending background precharge.
module rowbuf_seq
    import rowbuf_pkg::*;
#(
    parameter int T_PRE = 4,
    parameter int T_ACT = 4,
    parameter int T_COL = 4,
    parameter int CNT_W = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fire_i,
    input  logic       close_pol_i,
    input  acc_kind_e  kind_i,
    input  logic       drain_busy_i,
    input  logic       drain_last_i,
    output seq_state_e state_o,
    output logic       pol_o,
    output acc_kind_e  kind_o,
    output logic       done_o,
    output logic       fill_o,
    output logic       invalidate_o,
    output logic       drain_start_o
);

    localparam logic [CNT_W-1:0] LD_PRE = CNT_W'(T_PRE - 1);
    localparam logic [CNT_W-1:0] LD_ACT = CNT_W'(T_ACT - 1);
    localparam logic [CNT_W-1:0] LD_COL = CNT_W'(T_COL - 1);

    seq_state_e       st_q, st_n;
    logic             pol_q;
    acc_kind_e        kind_q;
    logic             done_q, done_n;
    logic             ld;
    logic [CNT_W-1:0] ld_val;
    logic             expired;

    rowbuf_phase_cnt #(.CNT_W(CNT_W)) u_phase (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (ld),
        .load_val_i (ld_val),
        .expired_o  (expired)
    );

    // Choose the next phase and the bank actions of this cycle.
    always_comb begin
        st_n          = st_q;
        ld            = 1'b0;
        ld_val        = '0;
        fill_o        = 1'b0;
        invalidate_o  = 1'b0;
        drain_start_o = 1'b0;
        done_n        = 1'b0;
        case (st_q)
            SQ_IDLE: begin
                if (fire_i) begin
                    case (kind_i)
                        ACC_HIT: begin
                            st_n   = SQ_COL;
                            ld     = 1'b1;
                            ld_val = LD_COL;
                        end
                        ACC_EMPTY: begin
                            if (drain_busy_i && !drain_last_i) begin
                                st_n = SQ_DRAIN;
                            end else begin
                                st_n   = SQ_ACT;
                                ld     = 1'b1;
                                ld_val = LD_ACT;
                            end
                        end
                        default: begin
                            st_n         = SQ_PRE;
                            ld           = 1'b1;
                            ld_val       = LD_PRE;
                            invalidate_o = 1'b1;
                        end
                    endcase
                end
            end
            SQ_DRAIN: begin
                if (drain_last_i) begin
                    st_n   = SQ_ACT;
                    ld     = 1'b1;
                    ld_val = LD_ACT;
                end
            end
            SQ_PRE: begin
                if (expired) begin
                    st_n   = SQ_ACT;
                    ld     = 1'b1;
                    ld_val = LD_ACT;
                end
            end
            SQ_ACT: begin
                if (expired) begin
                    st_n   = SQ_COL;
                    ld     = 1'b1;
                    ld_val = LD_COL;
                    fill_o = 1'b1;
                end
            end
            SQ_COL: begin
                if (expired) begin
                    st_n   = SQ_IDLE;
                    done_n = 1'b1;
                    if (pol_q) begin
                        invalidate_o  = 1'b1;
                        drain_start_o = 1'b1;
                    end
                end
            end
            default: st_n = SQ_IDLE;
        endcase
    end

    // Advance the phase state and register the completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= SQ_IDLE;
            done_q <= 1'b0;
        end else begin
            st_q   <= st_n;
            done_q <= done_n;
        end
    end

    // Capture policy and class of the accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pol_q  <= 1'b0;
            kind_q <= ACC_HIT;
        end else if (fire_i && st_q == SQ_IDLE) begin
            pol_q  <= close_pol_i;
            kind_q <= kind_i;
        end
    end

    // Expose the sequencer state.
    always_comb begin
        state_o = st_q;
        pol_o   = pol_q;
        kind_o  = kind_q;
        done_o  = done_q;
    end

endmodule

// File: rtl/bank_rowbuf_ctrl.sv
// Module: top of the single-bank row-buffer sequencer.
// Assumes: one request in flight; the row, column and policy are sampled at
// the accepting edge; every phase length parameter is at least 1.
module bank_rowbuf_ctrl
    import rowbuf_pkg::*;
#(
    parameter int ROW_W = 14,
    parameter int COL_W = 10,
    parameter int T_PRE = 4,
    parameter int T_ACT = 4,
    parameter int T_COL = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             close_page_i,
    input  logic             req_valid_i,
    input  logic [ROW_W-1:0] req_row_i,
    input  logic [COL_W-1:0] req_col_i,
    output logic             ready_o,
    output logic             done_o,
    output logic [1:0]       kind_o,
    output logic [COL_W-1:0] done_col_o,
    output logic             open_valid_o,
    output logic [ROW_W-1:0] open_row_o
);

    localparam int T_MAX = max3(T_PRE, T_ACT, T_COL);
    localparam int CNT_W = $clog2(T_MAX + 1);

    seq_state_e       seq_state;
    logic             fire;
    logic             pol_q;
    acc_kind_e        probe_kind;
    acc_kind_e        kind_q;
    logic             fill;
    logic             invalidate;
    logic             drain_start;
    logic             drain_busy;
    logic             drain_last;
    logic [ROW_W-1:0] row_q;
    logic [COL_W-1:0] col_q;

    // Accept a request only while idle.
    always_comb begin
        ready_o = (seq_state == SQ_IDLE);
        fire    = req_valid_i && ready_o;
    end

    // Hold the address of the request in flight.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_q <= '0;
            col_q <= '0;
        end else if (fire) begin
            row_q <= req_row_i;
            col_q <= req_col_i;
        end
    end

    rowbuf_tracker #(.ROW_W(ROW_W)) u_tracker (
        .clk          (clk),
        .rst_n        (rst_n),
        .probe_row_i  (req_row_i),
        .fill_i       (fill),
        .fill_row_i   (row_q),
        .invalidate_i (invalidate),
        .open_valid_o (open_valid_o),
        .open_row_o   (open_row_o),
        .kind_o       (probe_kind)
    );

    rowbuf_drain #(.T_PRE(T_PRE), .CNT_W(CNT_W)) u_drain (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (drain_start),
        .busy_o  (drain_busy),
        .last_o  (drain_last)
    );

    rowbuf_seq #(
        .T_PRE (T_PRE),
        .T_ACT (T_ACT),
        .T_COL (T_COL),
        .CNT_W (CNT_W)
    ) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .fire_i        (fire),
        .close_pol_i   (close_page_i),
        .kind_i        (probe_kind),
        .drain_busy_i  (drain_busy),
        .drain_last_i  (drain_last),
        .state_o       (seq_state),
        .pol_o         (pol_q),
        .kind_o        (kind_q),
        .done_o        (done_o),
        .fill_o        (fill),
        .invalidate_o  (invalidate),
        .drain_start_o (drain_start)
    );

    // Report class and column of the completed access.
    always_comb begin
        kind_o     = kind_q;
        done_col_o = col_q;
    end

endmodule

// File: rtl/bank_rowbuf_checker.sv
// Module: temporal checks on the row-buffer sequencer, bound to its top.
// Assumes: signals are sampled on the rising clock edge with reset active low.
module bank_rowbuf_checker
    import rowbuf_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid_i,
    input logic       ready_o,
    input logic       done_o,
    input logic [1:0] kind_o,
    input logic       open_valid_o,
    input logic       pol_q,
    input seq_state_e seq_state,
    input logic       drain_busy
);

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) done_o |=> !done_o); // R9
    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n) (req_valid_i && ready_o) |=> !ready_o); // R8
    AST_DONE_WHEN_READY: assert property (@(posedge clk) disable iff (!rst_n) done_o |-> ready_o); // R8
    AST_KIND_LEGAL: assert property (@(posedge clk) disable iff (!rst_n) done_o |-> (kind_o != 2'b11)); // R2
    AST_CLOSE_LEAVES_EMPTY: assert property (@(posedge clk) disable iff (!rst_n) (done_o && pol_q) |-> !open_valid_o); // R6
    AST_OPEN_KEEPS_ROW: assert property (@(posedge clk) disable iff (!rst_n) (done_o && !pol_q) |-> open_valid_o); // R5
    AST_NO_ACT_IN_DRAIN: assert property (@(posedge clk) disable iff (!rst_n) (seq_state == SQ_ACT) |-> !drain_busy); // R7

endmodule

bind bank_rowbuf_ctrl bank_rowbuf_checker u_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid_i  (req_valid_i),
    .ready_o      (ready_o),
    .done_o       (done_o),
    .kind_o       (kind_o),
    .open_valid_o (open_valid_o),
    .pol_q        (pol_q),
    .seq_state    (seq_state),
    .drain_busy   (drain_busy)
);

// File: tb/test_bank_rowbuf_ctrl.sv
// Bench: directed corner cases plus seeded random accesses, checked against
// latencies and classes computed from the requirements.
module test_bank_rowbuf_ctrl;

    localparam int ROW_W = 14;
    localparam int COL_W = 10;
    localparam int T_PRE = 4;
    localparam int T_ACT = 4;
    localparam int T_COL = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             close_page_i = 1'b0;
    logic             req_valid_i = 1'b0;
    logic [ROW_W-1:0] req_row_i = '0;
    logic [COL_W-1:0] req_col_i = '0;
    logic             ready_o;
    logic             done_o;
    logic [1:0]       kind_o;
    logic [COL_W-1:0] done_col_o;
    logic             open_valid_o;
    logic [ROW_W-1:0] open_row_o;

    int checks = 0;
    int failures = 0;

    // Bench model of the bank.
    bit               m_valid = 1'b0;
    logic [ROW_W-1:0] m_row = '0;
    bit               m_last_close = 1'b0;
    int               m_since = 1000;

    always #2 clk = ~clk;

    bank_rowbuf_ctrl #(
        .ROW_W (ROW_W), .COL_W (COL_W),
        .T_PRE (T_PRE), .T_ACT (T_ACT), .T_COL (T_COL)
    ) i_bank_rowbuf_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .close_page_i (close_page_i),
        .req_valid_i  (req_valid_i),
        .req_row_i    (req_row_i),
        .req_col_i    (req_col_i),
        .ready_o      (ready_o),
        .done_o       (done_o),
        .kind_o       (kind_o),
        .done_col_o   (done_col_o),
        .open_valid_o (open_valid_o),
        .open_row_o   (open_row_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_kind(input logic [ROW_W-1:0] row);
        if (!m_valid) return 1;
        if (m_row == row) return 0;
        return 2;
    endfunction

    function automatic int drain_left();
        if (m_last_close && m_since < T_PRE) return T_PRE - m_since;
        return 0;
    endfunction

    function automatic int exp_latency(input int kind, input int left);
        if (kind == 0) return T_COL;
        if (kind == 2) return T_PRE + T_ACT + T_COL;
        return T_ACT + T_COL + ((left > 0) ? left - 1 : 0);
    endfunction

    // One access: idle gap, request, optional ignored pulse, completion checks.
    task automatic access(input logic [ROW_W-1:0] row, input bit pol, input int gap, input bit noise);
        int kind;
        int left;
        int lat;
        int e;
        logic [COL_W-1:0] col;
        for (int g = 0; g < gap; g++) begin
            @(negedge clk);
            m_since++;
            check(done_o == 1'b0, "R9", int'(done_o), 0);
        end
        check(ready_o == 1'b1, "R8", int'(ready_o), 1);
        kind = exp_kind(row);
        left = drain_left();
        lat  = exp_latency(kind, left);
        col  = COL_W'($urandom);
        req_valid_i  = 1'b1;
        req_row_i    = row;
        req_col_i    = col;
        close_page_i = pol;
        @(negedge clk);
        req_valid_i  = 1'b0;
        close_page_i = ~pol;  // R10: changes after acceptance must not matter
        e = 0;
        check(ready_o == 1'b0, "R8", int'(ready_o), 0);
        check(done_o == 1'b0, "R9", int'(done_o), 0);
        while (!done_o && e < 200) begin
            if (noise && e == 1) begin
                req_valid_i = 1'b1;
                req_row_i   = ~row;
            end
            if (noise && e == 2) req_valid_i = 1'b0;
            @(negedge clk);
            e++;
        end
        if (kind == 0)      check(e == lat, "R2", e, lat);
        else if (kind == 2) check(e == lat, "R4", e, lat);
        else if (left > 1)  check(e == lat, "R7", e, lat);
        else                check(e == lat, "R3", e, lat);
        check(int'(kind_o) == kind, (kind == 0) ? "R2" : (kind == 1) ? "R3" : "R4", int'(kind_o), kind);
        check(done_col_o == col, "R2", int'(done_col_o), int'(col));
        if (pol) begin
            check(open_valid_o == 1'b0, "R6", int'(open_valid_o), 0);
            m_valid      = 1'b0;
            m_last_close = 1'b1;
        end else begin
            check(open_valid_o == 1'b1 && open_row_o == row, noise ? "R8" : "R5",
                  int'(open_row_o), int'(row));
            m_valid      = 1'b1;
            m_row        = row;
            m_last_close = 1'b0;
        end
        m_since = 0;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int seed_init;
        seed_init = $urandom(32'd20240611);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(ready_o == 1'b1, "R1", int'(ready_o), 1);
        check(done_o == 1'b0, "R1", int'(done_o), 0);
        check(open_valid_o == 1'b0, "R1", int'(open_valid_o), 0);

        access(14'd5, 1'b0, 2, 1'b0);   // R3 empty
        access(14'd5, 1'b0, 0, 1'b0);   // R2 hit, back to back
        access(14'd9, 1'b0, 1, 1'b0);   // R4 conflict
        access(14'd9, 1'b0, 0, 1'b1);   // R8 ignored pulse while busy
        access(14'd9, 1'b1, 0, 1'b0);   // R6 hit under close page
        access(14'd9, 1'b1, 0, 1'b0);   // R7 full remaining precharge
        access(14'd3, 1'b1, 1, 1'b0);   // R7 partial remaining precharge
        access(14'd3, 1'b0, 3, 1'b0);   // R7 last precharge cycle, no wait
        access('1,    1'b0, 4, 1'b0);   // R4 max row conflict
        access('1,    1'b0, 0, 1'b0);   // R2 max row hit

        for (int i = 0; i < 150; i++) begin
            access(ROW_W'($urandom_range(0, 3)), 1'($urandom_range(0, 1)),
                   $urandom_range(0, 6), 1'($urandom_range(0, 3) == 0));
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule